// File: doc/BRIEF.md
# Hybrid 90/150 Cellular Automaton Pattern Generator

This block produces pseudo-random stimulus for a circuit under test from a one-dimensional line of cells. Each cell updates from its own value and the values of its two adjacent cells, following one of two linear rules. The rule for each cell is fixed when the block is built, through a one-bit-per-cell rule parameter. The two outermost cells treat their missing outer neighbour as a constant zero. A well-chosen rule mix visits every nonzero state exactly once before it repeats.

The user loads a seed through a strobe and a seed bus. The array then advances one generation on every clock where run is high, and holds on every other clock. A small phase machine measures the cycle length of the loaded seed. It counts enabled steps until the array first returns to the seed, and then reports that count as the period. The same machine flags an all-zero seed, because that state maps to itself and the array would lock.

Phase machine states: `ST_SEARCH` (counting steps toward a return to the seed), `ST_FOUND` (period latched and reported), `ST_STUCK` (an all-zero seed was loaded). Transitions: reset goes to `ST_SEARCH`. A load with a nonzero seed goes from any state to `ST_SEARCH`. A load with a zero seed goes from any state to `ST_STUCK`. From `ST_SEARCH`, an enabled step whose next state equals the seed goes to `ST_FOUND`. Every other case holds the current state.

Top module: `ca_pattern_gen`

## Requirements
- R1: Synchronous reset sets the cells to `RESET_SEED` (default: cell 0 is 1, all other cells 0), sets period_vld_o and zero_err_o low, and starts a period search from that value.
- R2: A cell whose bit in `RULE_VEC` is 0 follows rule 90. Its next value is left XOR right, where state_o[i] is cell i, its left neighbour is cell i-1 and its right neighbour is cell i+1. A neighbour beyond either end is a constant 0.
- R3: A cell whose bit in `RULE_VEC` is 1 follows rule 150. Its next value is left XOR itself XOR right, with the same constant-zero ends.
- R4: When run_i and load_i are both low, state_o keeps its value.
- R5: When load_i is high, the cells take seed_i on that clock and no step occurs, even if run_i is also high.
- R6: After a nonzero load, period_o becomes the number of enabled steps taken until the cells first equal the seed again, and period_vld_o rises on that same clock. Both then stay fixed while stepping continues, until the next load clears period_vld_o.
- R7: Loading an all-zero seed raises zero_err_o on the following clock. The cells then stay all-zero while running. A later nonzero load clears the flag.
- R8: With the default 4 cells and `RULE_VEC` = 4'b1010 (cells 1 and 3 use rule 150), every nonzero seed has period 15. A 7-cell instance with `RULE_VEC` = 7'b1101010 has period 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Seed-load strobe; has priority over stepping |
| seed_i | input | N_CELLS | Seed value; bit i goes to cell i |
| run_i | input | 1 | Advances one generation per clock while high |
| state_o | output | N_CELLS | Present cell values, bit i is cell i |
| period_o | output | N_CELLS | Measured number of steps to return to the seed |
| period_vld_o | output | 1 | High once period_o holds a measured value |
| zero_err_o | output | 1 | High after an all-zero seed was loaded |

## Verification
The bench targets the end cells, where a design that wraps the array into a ring or feeds a cell its own value as the missing neighbour produces wrong patterns from seeds with a single set end bit. It asserts load and run together to catch a design that steps over a freshly loaded seed. It checks the exact step at which the period is reported, because an off-by-one counter or a comparison against the present state instead of the next state reports 14 or 16 instead of 15. It also loads a zero seed and confirms that the error flag appears and later clears, which a design that only checks the seed at reset would miss.

// File: rtl/ca_pkg.sv
package ca_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_FOUND  = 2'd1,
        ST_STUCK  = 2'd2
    } ca_phase_e;

    localparam bit RULE_90  = 1'b0;
    localparam bit RULE_150 = 1'b1;

endpackage

// File: rtl/ca_cell_array.sv
module ca_cell_array #(
    parameter int                N_CELLS  = 4,
    parameter logic [N_CELLS-1:0] RULE_VEC = '0
) (
    input  logic [N_CELLS-1:0] cur_i,
    output logic [N_CELLS-1:0] nxt_o
);
    import ca_pkg::*;

    localparam int LAST = N_CELLS - 1;

    // padded copy: bit 0 and bit N_CELLS+1 are the constant-zero ends
    logic [N_CELLS+1:0] padded;
    assign padded = {1'b0, cur_i, 1'b0};

    for (genvar i = 0; i <= LAST; i++) begin : g_cell
        logic left_nb;
        logic right_nb;
        assign left_nb  = padded[i];
        assign right_nb = padded[i+2];
        if (RULE_VEC[i] == RULE_150) begin : g_r150
            assign nxt_o[i] = left_nb ^ cur_i[i] ^ right_nb;
        end else begin : g_r90
            assign nxt_o[i] = left_nb ^ right_nb;
        end
    end

endmodule

// File: rtl/ca_state_reg.sv
module ca_state_reg #(
    parameter int                N_CELLS    = 4,
    parameter logic [N_CELLS-1:0] RESET_SEED = 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               load_i,
    input  logic [N_CELLS-1:0] seed_i,
    input  logic               run_i,
    input  logic [N_CELLS-1:0] nxt_i,
    output logic [N_CELLS-1:0] cells_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cells_o <= RESET_SEED;
        end else if (load_i) begin
            cells_o <= seed_i;
        end else if (run_i) begin
            cells_o <= nxt_i;
        end
    end

    // R4: idle clocks leave the cells untouched
    a_r4_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !run_i) |=> $stable(cells_o));

    // R5: a load wins over a step
    a_r5_load_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (cells_o == $past(seed_i)));

endmodule

// File: rtl/ca_period_ctrl.sv
module ca_period_ctrl #(
    parameter int                N_CELLS    = 4,
    parameter logic [N_CELLS-1:0] RESET_SEED = 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               load_i,
    input  logic [N_CELLS-1:0] seed_i,
    input  logic               run_i,
    input  logic [N_CELLS-1:0] nxt_i,
    input  logic [N_CELLS-1:0] cells_i,
    output logic [N_CELLS-1:0] period_o,
    output logic               period_vld_o,
    output logic               zero_err_o
);
    import ca_pkg::*;

    localparam int CNT_W = N_CELLS;

    ca_phase_e          phase_q, phase_d;
    logic [N_CELLS-1:0] seed_q;
    logic [CNT_W-1:0]   steps_q;
    logic [CNT_W-1:0]   steps_inc;
    logic               hit;

    assign steps_inc = steps_q + 1'b1;
    assign hit       = run_i && (nxt_i == seed_q);

    // next-phase logic
    always_comb begin
        phase_d = phase_q;
        if (load_i) begin
            phase_d = (seed_i == '0) ? ST_STUCK : ST_SEARCH;
        end else begin
            unique case (phase_q)
                ST_SEARCH: if (hit) phase_d = ST_FOUND;
                ST_FOUND:  phase_d = ST_FOUND;
                ST_STUCK:  phase_d = ST_STUCK;
                default:   phase_d = ST_SEARCH;
            endcase
        end
    end

    // phase register with seed, step counter and period
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q  <= ST_SEARCH;
            seed_q   <= RESET_SEED;
            steps_q  <= '0;
            period_o <= '0;
        end else begin
            phase_q <= phase_d;
            if (load_i) begin
                seed_q   <= seed_i;
                steps_q  <= '0;
                period_o <= '0;
            end else if (run_i && phase_q == ST_SEARCH) begin
                steps_q <= steps_inc;
                if (hit) period_o <= steps_inc;
            end
        end
    end

    // outputs
    always_comb begin
        period_vld_o = 1'b0;
        zero_err_o   = 1'b0;
        unique case (phase_q)
            ST_SEARCH: ;
            ST_FOUND:  period_vld_o = 1'b1;
            ST_STUCK:  zero_err_o   = 1'b1;
            default:   ;
        endcase
    end

    // R7: zero seed raises the error flag
    a_r7_zero_flag: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && seed_i == '0) |=> zero_err_o);

    // R6: the period is reported on the step that reaches the seed again
    a_r6_return_seen: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(period_vld_o) |-> (cells_i == seed_q));

    // R6: a reported period is never zero
    a_r6_nonzero: assert property (@(posedge clk_i) disable iff (rst_i)
        period_vld_o |-> (period_o != '0));

    // R6: a nonzero load restarts the search
    a_r6_load_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && seed_i != '0) |=> (!period_vld_o && !zero_err_o));

endmodule

// File: rtl/ca_pattern_gen.sv
module ca_pattern_gen #(
    parameter int                N_CELLS    = 4,
    parameter logic [N_CELLS-1:0] RULE_VEC   = 4'b1010,
    parameter logic [N_CELLS-1:0] RESET_SEED = 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               load_i,
    input  logic [N_CELLS-1:0] seed_i,
    input  logic               run_i,
    output logic [N_CELLS-1:0] state_o,
    output logic [N_CELLS-1:0] period_o,
    output logic               period_vld_o,
    output logic               zero_err_o
);

    logic [N_CELLS-1:0] nxt;

    ca_cell_array #(
        .N_CELLS (N_CELLS),
        .RULE_VEC(RULE_VEC)
    ) u_array (
        .cur_i(state_o),
        .nxt_o(nxt)
    );

    ca_state_reg #(
        .N_CELLS   (N_CELLS),
        .RESET_SEED(RESET_SEED)
    ) u_cells (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load_i),
        .seed_i (seed_i),
        .run_i  (run_i),
        .nxt_i  (nxt),
        .cells_o(state_o)
    );

    ca_period_ctrl #(
        .N_CELLS   (N_CELLS),
        .RESET_SEED(RESET_SEED)
    ) u_period (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .load_i      (load_i),
        .seed_i      (seed_i),
        .run_i       (run_i),
        .nxt_i       (nxt),
        .cells_i     (state_o),
        .period_o    (period_o),
        .period_vld_o(period_vld_o),
        .zero_err_o  (zero_err_o)
    );

endmodule

// File: tb/ca_pattern_gen_bench.sv
module ca_pattern_gen_bench;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst;
    logic       ld4, run4, ld7, run7;
    logic [3:0] sd4;
    logic [6:0] sd7;
    logic [3:0] st4, per4;
    logic [6:0] st7, per7;
    logic       vld4, err4, vld7, err7;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    ca_pattern_gen u_ca_pattern_gen (
        .clk_i(clk), .rst_i(rst), .load_i(ld4), .seed_i(sd4), .run_i(run4),
        .state_o(st4), .period_o(per4), .period_vld_o(vld4), .zero_err_o(err4));

    ca_pattern_gen #(.N_CELLS(7), .RULE_VEC(7'b1101010), .RESET_SEED(7'd1)) u_ca_pattern_gen_w7 (
        .clk_i(clk), .rst_i(rst), .load_i(ld7), .seed_i(sd7), .run_i(run7),
        .state_o(st7), .period_o(per7), .period_vld_o(vld7), .zero_err_o(err7));

    // model of one generation, cells beyond the ends read as zero
    function automatic logic [7:0] ca_step(logic [7:0] s, logic [7:0] r, int n);
        logic [7:0] res = '0;
        for (int i = 0; i < n; i++) begin
            logic lf, rt;
            lf = (i > 0)     ? s[i-1] : 1'b0;
            rt = (i < n - 1) ? s[i+1] : 1'b0;
            res[i] = lf ^ rt ^ (r[i] & s[i]);
        end
        return res;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // bench model of the 4-cell instance
    logic [3:0] m_st, m_seed;
    int  m_cnt, m_per;
    bit  m_vld, m_err;

    task automatic cyc4(bit ld, logic [3:0] sd, bit rn);
        string tag;
        @(negedge clk);
        ld4 = ld; sd4 = sd; run4 = rn;
        @(posedge clk); #1;
        if (ld) begin
            tag = "R5"; m_st = sd; m_seed = sd; m_cnt = 0; m_vld = 0; m_err = (sd == 0);
        end else if (rn) begin
            tag = "R2 R3";
            m_st = ca_step({4'b0, m_st}, 8'b0000_1010, 4)[3:0];
            if (!m_vld && !m_err) begin
                m_cnt++;
                if (m_st == m_seed) begin m_vld = 1; m_per = m_cnt; end
            end
        end else tag = "R4";
        chk(st4 == m_st, tag, "state", st4, m_st);
        chk(vld4 == m_vld, "R6", "period_vld", vld4, m_vld);
        chk(err4 == m_err, "R7", "zero_err", err4, m_err);
        if (m_vld) chk(per4 == m_per[3:0], "R6", "period", per4, m_per);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; ld4 = 0; run4 = 0; sd4 = '0; ld7 = 0; run7 = 0; sd7 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1: reset state
        chk(st4 == 4'd1, "R1", "reset state", st4, 1);
        chk(!vld4 && !err4, "R1", "reset flags", {vld4, err4}, 0);
        chk(st7 == 7'd1, "R1", "reset state w7", st7, 1);
        m_st = 4'd1; m_seed = 4'd1; m_cnt = 0; m_vld = 0; m_err = 0; m_per = 0;

        // R4: hold while idle
        repeat (3) cyc4(0, 4'h0, 0);
        // R8: full cycle from the reset value
        repeat (15) cyc4(0, 4'h0, 1);
        chk(vld4 && per4 == 4'd15, "R8", "period from reset seed", per4, 15);
        repeat (3) cyc4(0, 4'h0, 1);
        // R7: zero seed, with run held high
        cyc4(1, 4'h0, 1);
        repeat (4) cyc4(0, 4'h0, 1);
        chk(err4 && st4 == 4'h0, "R7", "locked at zero", st4, 0);
        // R5: load and run together; end cells alone
        cyc4(1, 4'h8, 1);
        chk(!err4, "R7", "error cleared by nonzero load", err4, 0);
        repeat (15) cyc4(0, 4'h0, 1);
        chk(per4 == 4'd15, "R8", "period from top cell", per4, 15);
        // R8: every nonzero seed
        for (int s = 1; s < 16; s++) begin
            cyc4(1, s[3:0], 0);
            repeat (15) cyc4(0, 4'h0, 1);
            chk(vld4 && per4 == 4'd15, "R8", "period per seed", per4, 15);
        end
        // random mix of loads, steps and idle clocks
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom_range(0, 99);
            cyc4(r < 6, 4'($urandom_range(0, 15)), r >= 30);
        end

        // R8: seven-cell instance period
        @(negedge clk); ld7 = 1; sd7 = 7'h40; run7 = 1;
        @(negedge clk); ld7 = 0;
        chk(st7 == 7'h40, "R5", "w7 load", st7, 64);
        begin
            logic [6:0] e7;
            e7 = 7'h40;
            for (int k = 1; k <= 127; k++) begin
                @(negedge clk);
                e7 = ca_step({1'b0, e7}, 8'b0110_1010, 7)[6:0];
                chk(st7 == e7, "R2 R3", "w7 state", st7, e7);
                chk(vld7 == (k == 127), "R6", "w7 valid timing", vld7, (k == 127));
            end
        end
        chk(per7 == 7'd127, "R8", "w7 period", per7, 127);
        run7 = 0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule